// File: doc/BRIEF.md
# Uncorrectable Error Status with First-Error Pointer

This block keeps the uncorrectable error status word of a link-level error reporting unit, together with a per-bit mask word and a per-bit severity word. Each error source raises a one-cycle event pulse on its own bit. The matching status bit sets and stays set until software writes a one to that bit position.

Alongside the status word the block keeps a pointer to the most important pending error. The pointer captures the first unmasked error it sees. A later fatal error may replace a pointer that names a non-fatal one. The pointer is only free to capture again once every unmasked status bit has been cleared. Status and pointer survive a warm reset and clear only on a cold (power-on) reset. Mask and severity return to zero on either reset.

Software reaches all four words through one write port and one combinational read port.

Top module: `uerr_first_ptr`

## Requirements
- R1: A cold reset (asynchronous, active low) sets status, mask, severity, pointer and valid flag to zero.
- R2: An event pulse on bit i sets status bit i at the next clock edge. A write to address 0 clears the status bits written as one and leaves the bits written as zero unchanged.
- R3: When an event on bit i and a clear of bit i fall in the same cycle, status bit i stays set.
- R4: While the valid flag is low, an unmasked event captures its bit index into the pointer and raises the valid flag at the same edge.
- R5: When several unmasked events of equal severity capture in the same cycle, the pointer takes the highest bit index among them.
- R6: A severity bit of 1 marks a fatal error and 0 a non-fatal one. At capture, fatal events win over non-fatal events in the same cycle. While valid with a non-fatal pointer, an unmasked fatal event overwrites the pointer with the highest such index.
- R7: While valid, a later event of equal or lower severity leaves the pointer unchanged.
- R8: A masked event (mask bit 1) still sets its status bit. It neither captures nor overwrites the pointer, and its status bit does not hold the valid flag.
- R9: The valid flag drops at the edge after which no unmasked status bit remains set. The pointer keeps its last value.
- R10: After the valid flag has dropped, the next unmasked event is captured afresh.
- R11: A warm reset (synchronous, active low) leaves status, pointer and valid flag unchanged and sets mask and severity to zero.
- R12: The read port returns status at address 0, mask at address 1, severity at address 2, and at address 3 the pointer in bits 4:0 with the valid flag in bit 5. The write port loads mask at address 1 and severity at address 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst_n | input | 1 | Warm reset, synchronous, active low |
| err_evt | input | 32 | One-cycle error event per status bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| status | output | 32 | Error status word |
| fep | output | 5 | First-error pointer |
| fep_valid | output | 1 | Pointer holds a captured error |

## Verification
Two pairs of functions can land in the same cycle. A software clear can meet a new event on the same bit, and a fatal overwrite can meet other events of mixed severity. The bench provokes both by driving an event together with a clear write to the same position, and by firing fatal and non-fatal events on one edge. In each case it judges the result from the status word and the pointer on the following cycle. It also checks a clear of the last unmasked bit while a masked bit is still set, which must drop the valid flag and keep the pointer value.

// File: rtl/uerr_first_ptr.sv
module uerr_first_ptr #(
  parameter int W  = 32,
  parameter int AW = 2,
  localparam int PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          cold_rst_n,
  input  logic          warm_rst_n,
  input  logic [W-1:0]  err_evt,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  status,
  output logic [PW-1:0] fep,
  output logic          fep_valid
);

  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_SEV  = AW'(2);
  localparam logic [AW-1:0] A_PTR  = AW'(3);

  logic [W-1:0] mask_q, sev_q;
  logic [W-1:0] clr, status_nxt, new_um, new_f;
  logic         pend_nxt;

  function automatic logic [PW-1:0] top_idx(input logic [W-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++)
      if (v[i]) r = PW'(i);
    return r;
  endfunction

  assign clr        = (wr_en && wr_addr == A_STAT) ? wr_data : '0;
  assign status_nxt = (status & ~clr) | err_evt;
  assign new_um     = err_evt & ~mask_q;
  assign new_f      = new_um & sev_q;
  assign pend_nxt   = |(status_nxt & ~mask_q);

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) status <= '0;
    else             status <= status_nxt;
  end

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      mask_q <= '0;
      sev_q  <= '0;
    end else if (!warm_rst_n) begin
      mask_q <= '0;
      sev_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_MASK) mask_q <= wr_data;
      if (wr_addr == A_SEV)  sev_q  <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      fep       <= '0;
      fep_valid <= 1'b0;
    end else if (!fep_valid) begin
      if (|new_um) begin
        fep       <= (|new_f) ? top_idx(new_f) : top_idx(new_um);
        fep_valid <= 1'b1;
      end
    end else if (!pend_nxt) begin
      fep_valid <= 1'b0;
    end else if (!sev_q[fep] && |new_f) begin
      fep <= top_idx(new_f);
    end
  end

  always_comb begin
    case (rd_addr)
      A_STAT:  rd_data = status;
      A_MASK:  rd_data = mask_q;
      A_SEV:   rd_data = sev_q;
      A_PTR:   rd_data = W'({fep_valid, fep});
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/uerr_first_ptr_chk.sv
module uerr_first_ptr_chk #(
  parameter int W  = 32,
  parameter int AW = 2,
  localparam int PW = $clog2(W)
) (
  input logic          clk,
  input logic          cold_rst_n,
  input logic          warm_rst_n,
  input logic [W-1:0]  err_evt,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [W-1:0]  status,
  input logic [PW-1:0] fep,
  input logic          fep_valid,
  input logic [W-1:0]  mask_q,
  input logic [W-1:0]  sev_q
);

  logic past_ok;
  always_ff @(posedge clk or negedge cold_rst_n)
    if (!cold_rst_n) past_ok <= 1'b0;
    else             past_ok <= 1'b1;

  a_r3_event_sets_status: assert property (@(posedge clk) disable iff (!cold_rst_n)
    past_ok |=> ((status & $past(err_evt)) == $past(err_evt)));

  a_r4_capture_sets_valid: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (past_ok && !fep_valid && |(err_evt & ~mask_q)) |=> (fep_valid && status[fep]));

  a_r7_fatal_ptr_held: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (past_ok && fep_valid && sev_q[fep]) |=> (fep == $past(fep)));

  a_r8_masked_no_capture: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (past_ok && !fep_valid && ((err_evt & ~mask_q) == '0)) |=> (!fep_valid && $stable(fep)));

  a_r9_rearm_when_clear: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (past_ok && fep_valid && ((status & ~mask_q) == '0) && ((err_evt & ~mask_q) == '0))
      |=> !fep_valid);

  a_r11_warm_keeps_sticky: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (past_ok && !warm_rst_n && err_evt == '0 && !(wr_en && wr_addr == '0))
      |=> ($stable(status) && $stable(fep) && mask_q == '0 && sev_q == '0));

endmodule

bind uerr_first_ptr uerr_first_ptr_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
  .err_evt(err_evt), .wr_en(wr_en), .wr_addr(wr_addr),
  .status(status), .fep(fep), .fep_valid(fep_valid),
  .mask_q(mask_q), .sev_q(sev_q)
);

// File: tb/uerr_first_ptr_bench.sv
`timescale 1ns/1ps
module uerr_first_ptr_bench;

  logic        clk = 0;
  logic        cold_rst_n = 0;
  logic        warm_rst_n = 1;
  logic [31:0] err_evt = '0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data, status;
  logic [4:0]  fep;
  logic        fep_valid;

  int checks = 0, fails = 0, cnt = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] st;
    logic [4:0]  p;
    logic        v;
    logic [31:0] rd;
    int          stamp;
    string       tag;
  } exp_t;
  exp_t q[$];

  uerr_first_ptr u_uerr_first_ptr (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .err_evt(err_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .status(status),
    .fep(fep), .fep_valid(fep_valid)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1;

  task automatic compare(input exp_t e);
    checks++;
    if (status !== e.st || fep !== e.p || fep_valid !== e.v || rd_data !== e.rd) begin
      fails++;
      $display("FAIL %s: got st=%h ptr=%0d v=%b rd=%h, expected st=%h ptr=%0d v=%b rd=%h",
               e.tag, status, fep, fep_valid, rd_data, e.st, e.p, e.v, e.rd);
    end
  endtask

  always @(negedge clk)
    while (q.size() > 0 && q[0].stamp < cnt) compare(q.pop_front());

  task automatic cyc(input logic [31:0] ev, input logic we, input logic [1:0] wa,
                     input logic [31:0] wd, input logic [1:0] ra, input logic wrn,
                     input logic [31:0] es, input logic [4:0] ep, input logic evv,
                     input logic [31:0] erd, input string tag);
    exp_t e;
    @(negedge clk); #1;
    err_evt = ev; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; warm_rst_n = wrn;
    e.st = es; e.p = ep; e.v = evv; e.rd = erd; e.stamp = cnt; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    exp_t e;
    #12;
    rd_addr = 2'd3; #1;
    e.st = 0; e.p = 0; e.v = 0; e.rd = 0; e.stamp = 0; e.tag = "R1 power-on state";
    compare(e);
    @(negedge clk); #1 cold_rst_n = 1;

    cyc(0, 1, 2, 32'h0F00, 2, 1, 32'h0, 0, 0, 32'h0F00, "R12 severity write/read");
    cyc(0, 1, 1, 32'h0001, 1, 1, 32'h0, 0, 0, 32'h0001, "R12 mask write/read");
    cyc(32'h1, 0, 0, 0, 3, 1, 32'h1, 0, 0, 32'h0, "R8 masked event no capture");
    cyc(32'h28, 0, 0, 0, 3, 1, 32'h29, 5, 1, 32'h25, "R5 R4 equal severity picks top");
    cyc(32'h80, 0, 0, 0, 0, 1, 32'hA9, 5, 1, 32'hA9, "R7 later non-fatal ignored");
    cyc(32'h200, 1, 0, 32'h8, 0, 1, 32'h2A1, 9, 1, 32'h2A1, "R6 R2 fatal overwrite and clear");
    cyc(32'h400, 0, 0, 0, 0, 1, 32'h6A1, 9, 1, 32'h6A1, "R7 equal fatal ignored");
    cyc(32'h2, 0, 0, 0, 0, 1, 32'h6A3, 9, 1, 32'h6A3, "R7 lower severity ignored");
    cyc(0, 0, 0, 0, 2, 0, 32'h6A3, 9, 1, 32'h0, "R11 warm reset keeps sticky");
    cyc(0, 1, 2, 32'h0F00, 1, 1, 32'h6A3, 9, 1, 32'h0, "R11 mask back to zero");
    cyc(0, 1, 1, 32'h0001, 1, 1, 32'h6A3, 9, 1, 32'h1, "R12 mask restored");
    cyc(32'h80, 1, 0, 32'h80, 0, 1, 32'h6A3, 9, 1, 32'h6A3, "R3 event wins over clear");
    cyc(0, 1, 0, 32'h0, 0, 1, 32'h6A3, 9, 1, 32'h6A3, "R2 write zero no effect");
    cyc(0, 1, 0, 32'h6A2, 0, 1, 32'h1, 9, 0, 32'h1, "R9 R8 re-arm with masked bit set");
    cyc(32'h1, 0, 0, 0, 3, 1, 32'h1, 9, 0, 32'h09, "R8 masked event after re-arm");
    cyc(32'h14, 0, 0, 0, 3, 1, 32'h15, 4, 1, 32'h24, "R10 fresh capture");
    cyc(0, 1, 0, 32'h14, 0, 1, 32'h1, 4, 0, 32'h1, "R9 second re-arm");
    cyc(32'h100800, 0, 0, 0, 0, 1, 32'h100801, 11, 1, 32'h100801, "R6 fatal wins same cycle");
    cyc(32'h100, 0, 0, 0, 0, 1, 32'h100901, 11, 1, 32'h100901, "R7 fatal after fatal ignored");
    @(negedge clk); #1;
    err_evt = 0; wr_en = 0; warm_rst_n = 1;
    @(negedge clk); @(negedge clk); #1;
    cold_rst_n = 0; rd_addr = 2'd2; #1;
    e.st = 0; e.p = 0; e.v = 0; e.rd = 0; e.tag = "R1 cold reset clears all";
    compare(e);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
      $finish;
    end
  end

endmodule